// File: doc/BRIEF.md
# Byte and Halfword Lane Extractor

This block takes a 32-bit word, picks out one 8-bit or one 16-bit lane, and widens it back to 32 bits. Software uses it to build unaligned loads out of aligned ones and to sign- or zero-extend narrow values. The output is purely combinational. There is no clock, no state and no handshake, so the result follows the inputs within the same cycle.

The lane index can come from one of two places. In the register form, the index is the low bits of a second register operand, and the selected field is always zero-extended. In the immediate form, the index comes from a short instruction immediate, and the caller chooses sign or zero extension. Lane 0 is always the least significant lane. A byte lane is chosen by index bits [1:0]. A halfword lane is chosen by index bit [1] alone. All other index bits are ignored.

Top module: `lane_extract_unit`

## Requirements
- R1: With `use_imm`=0 and `is_half`=0, `result` equals byte number `lane_reg[1:0]` of `src_word`, zero-extended. Byte n occupies bits [8n+7:8n], so byte 0 is bits [7:0].
- R2: With `use_imm`=0 and `is_half`=1, `result` equals halfword number `lane_reg[1]` of `src_word`, zero-extended. Halfword 0 is bits [15:0] and halfword 1 is bits [31:16].
- R3: In the register form (`use_imm`=0), `sign_req` has no effect. Bits above the selected field are always 0.
- R4: With `use_imm`=1, `is_half`=0 and `sign_req`=1, `result` equals byte `lane_imm[1:0]` of `src_word`, with its bit 7 copied into result bits [31:8].
- R5: With `use_imm`=1 and `sign_req`=0, the selected byte (index `lane_imm[1:0]`) or halfword (index `lane_imm[1]`) is zero-extended.
- R6: With `use_imm`=1, `is_half`=1 and `sign_req`=1, `result` equals halfword `lane_imm[1]` of `src_word`, with its bit 15 copied into result bits [31:16].
- R7: Index bits above bit 1 have no effect on `result`. In halfword mode, index bit 0 also has no effect.
- R8: In the register form, `lane_imm` has no effect. In the immediate form, `lane_reg` has no effect.
- R9: `result` is a combinational function of the current inputs. Once the inputs change, the new value is present without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_word | input | 32 | Word the lane is taken from |
| lane_reg | input | 32 | Register operand whose low bits give the lane in the register form |
| lane_imm | input | 4 | Immediate whose low bits give the lane in the immediate form |
| use_imm | input | 1 | 0 = register form, 1 = immediate form |
| is_half | input | 1 | 0 = byte lane, 1 = halfword lane |
| sign_req | input | 1 | 1 = sign-extend; honoured only in the immediate form |
| result | output | 32 | Selected lane, widened to 32 bits |

## Verification
Deferred immediate assertions run whenever the inputs settle. They check three properties against the inputs: the low field of `result` matches the lane addressed by the active index source, the upper bits are zero in every unsigned case, and the upper bits copy the field's top bit in the signed immediate cases. Three kinds of behaviour are left to the bench scenarios. The first is that ignored inputs (upper index bits, the unused index source, `sign_req` in the register form) leave `result` unchanged, which needs two comparable stimuli. The second is walking every lane with distinctive data. The third is the settling of `result` with no clock.

// File: rtl/lane_extract_pkg.sv
package lane_extract_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned IMM_W  = 4;

  typedef enum logic {
    FORM_REG = 1'b0,
    FORM_IMM = 1'b1
  } lane_form_e;

  typedef enum logic {
    SIZE_BYTE = 1'b0,
    SIZE_HALF = 1'b1
  } lane_size_e;
endpackage

// File: rtl/lane_pick.sv
module lane_pick #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned FIELD_W = 8,
  localparam int unsigned LANES  = WORD_W / FIELD_W,
  localparam int unsigned IDX_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [WORD_W-1:0]  word_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [FIELD_W-1:0] field_o
);
  logic [FIELD_W-1:0] lane_q [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_q[g] = word_i[g*FIELD_W +: FIELD_W];
  end

  always_comb begin
    field_o = lane_q[0];
    for (int k = 0; k < LANES; k++) begin
      if (idx_i == IDX_W'(k)) field_o = lane_q[k];
    end
  end
endmodule

// File: rtl/lane_widen.sv
module lane_widen #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned FIELD_W = 8,
  localparam int unsigned FILL_W = WORD_W - FIELD_W
) (
  input  logic [FIELD_W-1:0] field_i,
  input  logic               sign_en_i,
  output logic [WORD_W-1:0]  word_o
);
  logic fill_bit;
  assign fill_bit = sign_en_i & field_i[FIELD_W-1];
  assign word_o   = {{FILL_W{fill_bit}}, field_i};
endmodule

// File: rtl/lane_extract_unit.sv
module lane_extract_unit
  import lane_extract_pkg::*;
(
  input  logic [WORD_W-1:0] src_word,
  input  logic [WORD_W-1:0] lane_reg,
  input  logic [IMM_W-1:0]  lane_imm,
  input  logic              use_imm,
  input  logic              is_half,
  input  logic              sign_req,
  output logic [WORD_W-1:0] result
);
  localparam int unsigned BYTE_LANES = WORD_W / BYTE_W;
  localparam int unsigned BIDX_W     = $clog2(BYTE_LANES);
  localparam int unsigned HIDX_W     = BIDX_W - 1;

  lane_form_e form;
  lane_size_e size;
  assign form = lane_form_e'(use_imm);
  assign size = lane_size_e'(is_half);

  logic [BIDX_W-1:0] lane_sel;
  logic              sign_eff;
  assign lane_sel = (form == FORM_IMM) ? lane_imm[BIDX_W-1:0] : lane_reg[BIDX_W-1:0];
  assign sign_eff = (form == FORM_IMM) & sign_req;

  logic unused_idx_bits;
  assign unused_idx_bits = ^{lane_reg[WORD_W-1:BIDX_W], lane_imm[IMM_W-1:BIDX_W]};

  logic [BYTE_W-1:0] byte_field;
  logic [HALF_W-1:0] half_field;
  logic [WORD_W-1:0] byte_word, half_word;

  lane_pick #(.WORD_W(WORD_W), .FIELD_W(BYTE_W)) u_pick_byte (
    .word_i(src_word), .idx_i(lane_sel), .field_o(byte_field));

  lane_pick #(.WORD_W(WORD_W), .FIELD_W(HALF_W)) u_pick_half (
    .word_i(src_word), .idx_i(lane_sel[BIDX_W-1 -: HIDX_W]), .field_o(half_field));

  lane_widen #(.WORD_W(WORD_W), .FIELD_W(BYTE_W)) u_widen_byte (
    .field_i(byte_field), .sign_en_i(sign_eff), .word_o(byte_word));

  lane_widen #(.WORD_W(WORD_W), .FIELD_W(HALF_W)) u_widen_half (
    .field_i(half_field), .sign_en_i(sign_eff), .word_o(half_word));

  assign result = (size == SIZE_HALF) ? half_word : byte_word;

  logic [WORD_W-1:0] shifted_src;
  assign shifted_src = src_word >> (BYTE_W * lane_sel);

  always_comb begin
    if (size == SIZE_BYTE) begin
      // R1 / R4 / R5: low field is the addressed byte
      p_byte_lane_r1: assert final (result[BYTE_W-1:0] == shifted_src[BYTE_W-1:0]);
    end
    if (size == SIZE_HALF) begin
      // R2 / R6: low field is the addressed halfword (index bit 0 ignored)
      p_half_lane_r2: assert final (result[HALF_W-1:0] ==
                                    src_word[(lane_sel[1] ? HALF_W : 0) +: HALF_W]);
    end
    if (!use_imm && !is_half) begin
      p_reg_byte_zero_r3: assert final (result[WORD_W-1:BYTE_W] == '0);
    end
    if (!use_imm && is_half) begin
      p_reg_half_zero_r3: assert final (result[WORD_W-1:HALF_W] == '0);
    end
    if (use_imm && sign_req && !is_half) begin
      p_byte_fill_r4: assert final (result[WORD_W-1:BYTE_W] ==
                                    {(WORD_W-BYTE_W){result[BYTE_W-1]}});
    end
    if (use_imm && !sign_req) begin
      p_imm_unsigned_r5: assert final (is_half ? (result[WORD_W-1:HALF_W] == '0)
                                               : (result[WORD_W-1:BYTE_W] == '0));
    end
    if (use_imm && sign_req && is_half) begin
      p_half_fill_r6: assert final (result[WORD_W-1:HALF_W] ==
                                    {(WORD_W-HALF_W){result[HALF_W-1]}});
    end
  end
endmodule

// File: tb/test_lane_extract_unit.sv
module test_lane_extract_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [31:0] src_word, lane_reg, result;
  logic [3:0]  lane_imm;
  logic        use_imm, is_half, sign_req;

  lane_extract_unit i_lane_extract_unit (
    .src_word(src_word), .lane_reg(lane_reg), .lane_imm(lane_imm),
    .use_imm(use_imm), .is_half(is_half), .sign_req(sign_req), .result(result));

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [31:0] model(input logic [31:0] w, input logic [31:0] r,
      input logic [3:0] im, input logic ui, input logic hf, input logic sg);
    int idx;
    logic [31:0] v;
    idx = ui ? int'(im % 4) : int'(r % 4);
    if (hf) begin
      v = (w >> ((idx / 2) * 16)) & 32'h0000_FFFF;
      if (ui && sg && v[15]) v = v | 32'hFFFF_0000;
    end else begin
      v = (w >> (idx * 8)) & 32'h0000_00FF;
      if (ui && sg && v[7]) v = v | 32'hFFFF_FF00;
    end
    return v;
  endfunction

  task automatic drive(input logic [31:0] w, input logic [31:0] r, input logic [3:0] im,
      input logic ui, input logic hf, input logic sg, input string tag);
    @(posedge clk);
    src_word = w; lane_reg = r; lane_imm = im;
    use_imm = ui; is_half = hf; sign_req = sg;
    exp_q.push_back(model(w, r, im, ui, hf, sg));
    tag_q.push_back(tag);
  endtask

  task automatic drive_exp(input logic [31:0] w, input logic [31:0] r, input logic [3:0] im,
      input logic ui, input logic hf, input logic sg, input logic [31:0] e, input string tag);
    @(posedge clk);
    src_word = w; lane_reg = r; lane_imm = im;
    use_imm = ui; is_half = hf; sign_req = sg;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (result !== e) begin
        bad++;
        $display("FAIL %s: result=%h expected=%h", t, result, e);
      end
    end
  end

  initial begin
    src_word = '0; lane_reg = '0; lane_imm = '0;
    use_imm = 1'b0; is_half = 1'b0; sign_req = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (result !== 32'h0) begin
      bad++;
      $display("FAIL reset/R9: result=%h expected=%h", result, 32'h0);
    end
    rst = 1'b0;

    // R1: every byte lane, register form
    for (int k = 0; k < 4; k++) drive(32'h8765_43A1, 32'(k), 4'h0, 1'b0, 1'b0, 1'b0, "R1");
    drive_exp(32'h8765_43A1, 32'h0, 4'h0, 1'b0, 1'b0, 1'b0, 32'h0000_00A1, "R1 lane0");
    // R2: halfword lanes, register form
    drive_exp(32'h8765_C321, 32'h0, 4'h0, 1'b0, 1'b1, 1'b0, 32'h0000_C321, "R2 lane0");
    drive_exp(32'h8765_C321, 32'h2, 4'h0, 1'b0, 1'b1, 1'b0, 32'h0000_8765, "R2 lane1");
    // R3: sign_req has no effect in the register form
    drive_exp(32'hF0E0_D0C0, 32'h3, 4'h0, 1'b0, 1'b0, 1'b1, 32'h0000_00F0, "R3 byte");
    drive_exp(32'hF0E0_D0C0, 32'h0, 4'h0, 1'b0, 1'b1, 1'b1, 32'h0000_D0C0, "R3 half");
    // R4: signed byte, immediate form
    drive_exp(32'h1280_7F00, 32'h0, 4'h2, 1'b1, 1'b0, 1'b1, 32'hFFFF_FF80, "R4 neg");
    drive_exp(32'h1280_7F00, 32'h0, 4'h1, 1'b1, 1'b0, 1'b1, 32'h0000_007F, "R4 pos");
    for (int k = 0; k < 4; k++) drive(32'h80FF_017E, 32'h0, 4'(k), 1'b1, 1'b0, 1'b1, "R4");
    // R5: unsigned immediate form
    drive_exp(32'h1280_7F00, 32'h0, 4'h2, 1'b1, 1'b0, 1'b0, 32'h0000_0080, "R5 byte");
    drive_exp(32'h9000_0001, 32'h0, 4'h2, 1'b1, 1'b1, 1'b0, 32'h0000_9000, "R5 half");
    // R6: signed halfword, immediate form
    drive_exp(32'h9000_7FFF, 32'h0, 4'h2, 1'b1, 1'b1, 1'b1, 32'hFFFF_9000, "R6 neg");
    drive_exp(32'h9000_7FFF, 32'h0, 4'h0, 1'b1, 1'b1, 1'b1, 32'h0000_7FFF, "R6 pos");
    // R7: upper index bits and half-mode bit 0 ignored
    drive_exp(32'hAABB_CCDD, 32'hFFFF_FFF1, 4'h0, 1'b0, 1'b0, 1'b0, 32'h0000_00CC, "R7 reg high");
    drive_exp(32'hAABB_CCDD, 32'h0, 4'hE, 1'b1, 1'b0, 1'b0, 32'h0000_00BB, "R7 imm high");
    drive_exp(32'hAABB_CCDD, 32'h3, 4'h0, 1'b0, 1'b1, 1'b0, 32'h0000_AABB, "R7 half bit0");
    drive_exp(32'hAABB_CCDD, 32'h0, 4'h1, 1'b1, 1'b1, 1'b0, 32'h0000_CCDD, "R7 imm half bit0");
    // R8: the inactive index source has no effect
    drive_exp(32'h1122_3344, 32'h0, 4'h3, 1'b0, 1'b0, 1'b0, 32'h0000_0044, "R8 imm ignored");
    drive_exp(32'h1122_3344, 32'h3, 4'h0, 1'b1, 1'b0, 1'b0, 32'h0000_0044, "R8 reg ignored");
    // mixed sweep
    for (int k = 0; k < 48; k++)
      drive(32'h9E37_79B9 * 32'(k + 1), 32'h3C6E_F372 * 32'(k), 4'(k * 7),
            1'((k >> 1) & 1), 1'(k & 1), 1'((k >> 2) & 1), "R1..R6 sweep");
    // R9: result settles with no clock edge
    @(posedge clk);
    #1;
    src_word = 32'h00C3_0000; lane_reg = 32'h2; use_imm = 1'b0; is_half = 1'b0; sign_req = 1'b0;
    #0.5;
    total++;
    if (result !== 32'h0000_00C3) begin
      bad++;
      $display("FAIL R9: result=%h expected=%h", result, 32'h0000_00C3);
    end
    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      total++;
      bad++;
      $display("FAIL watchdog: cycles=%0d expected below=%0d", cycles, 5000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule